// File: doc/BRIEF.md
# Contact Wetting Pulse and Thermal Alert Controller

This block decides, clock by clock, which switch inputs receive contact-cleaning (wetting) current, and it keeps track of the overtemperature condition that overrides that current. A debounce stage upstream reports the debounced closed-switch vector and a one-cycle strobe each time a change is accepted. The block turns these into one enable per input. In pulse-limited mode it uses one shared countdown timer. In unlimited mode the enables follow the closed switches directly. A scan-mode polling window, a direct-input mask on the low inputs and the thermal condition then gate the enables.

Two comparator inputs provide the thermal state: one is high above the warning temperature, the other is high below the recovery temperature. From these the block holds an overtemperature status bit with hysteresis. It also drives a separate active-low alert that a falling edge of the bus chip-select acknowledges. All thermal behaviour is inactive while wetting is disabled.

Top module: `wet_thermal_ctl`

## Requirements
- R1: Under reset (rst_n low at a clock edge) all wetting enables are 0, ot_alert_n is 1 and ot_status is 0 after that edge.
- R2: With wetting enabled and the pulse-limit bit 0, wet_en_o equals the closed vector (bit i = input i, 1 = closed) one cycle after it is presented.
- R3: While direct_mode is 1, wet_en_o bits 0 and 1 are 0, starting one cycle later; the other bits are unaffected.
- R4: While scan_mode is 1, wet_en_o is 0 unless poll_pulse is 1; during the polling pulse the enables are as in R2 or R5.
- R5: With the pulse-limit bit 1, a deb_done strobe captures the closed vector. That vector drives wet_en_o for PULSE_TICKS cycles, starting two cycles after the strobe is presented. Later changes of the closed inputs do not alter the pulse, and wet_en_o is 0 afterwards.
- R6: A new strobe during an active pulse restarts the single shared timer with a fresh capture, so the combined pulse is longer than PULSE_TICKS.
- R7: While wet_enable is 0, wet_en_o is 0 one cycle later, the timer is cleared, ot_status stays 0 and ot_alert_n stays 1 even with temp_hot high.
- R8: ot_status becomes 1 one cycle after temp_hot is seen high. It holds while temp_cool is low, even if temp_hot falls, and becomes 0 one cycle after temp_cool is seen high.
- R9: ot_alert_n falls one cycle after ot_status rises from 0. It returns to 1 one cycle after cs_fall, even while the device is still hot, and it does not fall again until a new crossing.
- R10: While ot_status is 1, wet_en_o is 0 from the next cycle on; the enables return one cycle after ot_status clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| deb_done | input | 1 | One-cycle strobe: a debounced change was accepted |
| closed | input | 8 | Debounced switch state, 1 = closed |
| wet_enable | input | 1 | Wetting current enable (configuration) |
| pulse_limit | input | 1 | 1 = timed pulse, 0 = continuous wetting |
| direct_mode | input | 1 | Inputs 0 and 1 used as direct inputs |
| scan_mode | input | 1 | Scan (polling) mode active |
| poll_pulse | input | 1 | Scan polling window |
| temp_hot | input | 1 | Comparator: above warning temperature |
| temp_cool | input | 1 | Comparator: below recovery temperature |
| cs_fall | input | 1 | One-cycle strobe on chip-select falling edge |
| wet_en_o | output | 8 | Per-input wetting current enable |
| ot_alert_n | output | 1 | Active-low overtemperature alert |
| ot_status | output | 1 | Overtemperature status bit with hysteresis |

## Verification
Every output is registered. Status and alert respond one cycle after the inputs that drive them. Unlimited, scan and direct-mode enables also respond one cycle later. Thermal gating of the enables comes one cycle after the status bit, so two cycles after temp_hot. A pulse is due from the second cycle after its strobe, for PULSE_TICKS cycles. The driver computes each expected item with its due cycle before it applies the stimulus. The monitor compares only on falling clock edges when the cycle count matches, so both the first and last pulse cycles and the cycle just after the pulse are checked exactly.

// File: rtl/wt_pkg.sv
// Shared constants for the wetting and thermal controller.
// Assumes: inputs numbered from 0; the direct-input group is the lowest bits.
package wt_pkg;
    localparam int WT_NUM_INPUTS = 8;
    localparam int WT_NUM_DIRECT = 2;
    localparam int WT_PULSE_TICKS = 40;

    // Combined thermal state passed from the monitor to the enable stage.
    typedef struct packed {
        logic status;
        logic alert;
    } wt_therm_t;
endpackage

// File: rtl/wt_pulse_timer.sv
// Shared wetting pulse timer: one countdown serves all inputs.
// A strobe loads the full period and captures the closed vector; a strobe
// during a running pulse restarts it. Assumes the strobe lasts one cycle.
module wt_pulse_timer #(
    parameter int NUM_INPUTS  = wt_pkg::WT_NUM_INPUTS,
    parameter int PULSE_TICKS = wt_pkg::WT_PULSE_TICKS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_en,
    input  logic                  strobe,
    input  logic [NUM_INPUTS-1:0] closed_now,
    output logic                  active,
    output logic [NUM_INPUTS-1:0] captured
);
    localparam int CW = $clog2(PULSE_TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_TICKS);

    logic [CW-1:0] count_q;

    // Countdown: reload on a strobe, clear when timed mode is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            count_q <= '0;
        end else if (strobe) begin
            count_q <= LOAD;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    // Capture the closed switches at the moment the pulse (re)starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            captured <= '0;
        end else if (run_en && strobe) begin
            captured <= closed_now;
        end
    end

    assign active = (count_q != '0);
endmodule

// File: rtl/wt_thermal_mon.sv
// Overtemperature tracking: a status bit with hysteresis between two
// comparator inputs, and an alert flag set on a crossing and acknowledged by
// a chip-select falling edge. Assumes comparators are already synchronised.
module wt_thermal_mon (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             hot,
    input  logic             cool,
    input  logic             ack,
    output wt_pkg::wt_therm_t therm
);
    logic status_q;
    logic alert_q;
    logic crossing;

    assign crossing = hot && !status_q;

    // Status bit: set above warning level, clear only at recovery level.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            status_q <= 1'b0;
        end else if (hot) begin
            status_q <= 1'b1;
        end else if (cool) begin
            status_q <= 1'b0;
        end
    end

    // Alert flag: set on a new crossing, acknowledge has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            alert_q <= 1'b0;
        end else if (ack) begin
            alert_q <= 1'b0;
        end else if (crossing) begin
            alert_q <= 1'b1;
        end
    end

    assign therm.status = status_q;
    assign therm.alert  = alert_q;
endmodule

// File: rtl/wt_enable_mux.sv
// Per-input wetting enable selection and gating, registered.
// Picks the timed capture or the live closed vector, then applies the
// direct-input mask, the scan polling window and the thermal override.
module wt_enable_mux #(
    parameter int NUM_INPUTS = wt_pkg::WT_NUM_INPUTS,
    parameter int NUM_DIRECT = wt_pkg::WT_NUM_DIRECT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wet_on,
    input  logic                  timed,
    input  logic                  pulse_active,
    input  logic [NUM_INPUTS-1:0] captured,
    input  logic [NUM_INPUTS-1:0] closed_now,
    input  logic                  direct_mode,
    input  logic                  scan_mode,
    input  logic                  poll_pulse,
    input  logic                  over_temp,
    output logic [NUM_INPUTS-1:0] wet_en
);
    logic [NUM_INPUTS-1:0] source;
    logic [NUM_INPUTS-1:0] masked;
    logic                  global_ok;

    // Source select: timed capture while pulsing, else live switches.
    always_comb begin
        if (timed) begin
            source = pulse_active ? captured : '0;
        end else begin
            source = closed_now;
        end
    end

    // Per-bit direct-input mask on the low group only.
    for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_mask
        if (i < NUM_DIRECT) begin : g_direct
            assign masked[i] = source[i] && !direct_mode;
        end else begin : g_plain
            assign masked[i] = source[i];
        end
    end

    assign global_ok = wet_on && !over_temp && (!scan_mode || poll_pulse);

    // Output register for the enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wet_en <= '0;
        end else begin
            wet_en <= global_ok ? masked : '0;
        end
    end
endmodule

// File: rtl/wet_thermal_ctl.sv
// Top: contact wetting pulse generation and overtemperature alert.
// Assumes deb_done and cs_fall are single-cycle strobes in the clk domain.
module wet_thermal_ctl #(
    parameter int NUM_INPUTS  = wt_pkg::WT_NUM_INPUTS,
    parameter int NUM_DIRECT  = wt_pkg::WT_NUM_DIRECT,
    parameter int PULSE_TICKS = wt_pkg::WT_PULSE_TICKS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  deb_done,
    input  logic [NUM_INPUTS-1:0] closed,
    input  logic                  wet_enable,
    input  logic                  pulse_limit,
    input  logic                  direct_mode,
    input  logic                  scan_mode,
    input  logic                  poll_pulse,
    input  logic                  temp_hot,
    input  logic                  temp_cool,
    input  logic                  cs_fall,
    output logic [NUM_INPUTS-1:0] wet_en_o,
    output logic                  ot_alert_n,
    output logic                  ot_status
);
    logic                  timed_run;
    logic                  pulse_active;
    logic [NUM_INPUTS-1:0] captured;
    wt_pkg::wt_therm_t     therm;

    assign timed_run = wet_enable && pulse_limit;

    wt_pulse_timer #(
        .NUM_INPUTS (NUM_INPUTS),
        .PULSE_TICKS(PULSE_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (timed_run),
        .strobe    (deb_done),
        .closed_now(closed),
        .active    (pulse_active),
        .captured  (captured)
    );

    wt_thermal_mon u_therm (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(wet_enable),
        .hot   (temp_hot),
        .cool  (temp_cool),
        .ack   (cs_fall),
        .therm (therm)
    );

    wt_enable_mux #(
        .NUM_INPUTS(NUM_INPUTS),
        .NUM_DIRECT(NUM_DIRECT)
    ) u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .wet_on      (wet_enable),
        .timed       (pulse_limit),
        .pulse_active(pulse_active),
        .captured    (captured),
        .closed_now  (closed),
        .direct_mode (direct_mode),
        .scan_mode   (scan_mode),
        .poll_pulse  (poll_pulse),
        .over_temp   (therm.status),
        .wet_en      (wet_en_o)
    );

    assign ot_status  = therm.status;
    assign ot_alert_n = !therm.alert;
endmodule

// File: rtl/wet_thermal_ctl_chk.sv
// Property checker for wet_thermal_ctl, attached by bind.
module wet_thermal_ctl_chk #(
    parameter int NUM_INPUTS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wet_enable,
    input logic                  direct_mode,
    input logic                  scan_mode,
    input logic                  poll_pulse,
    input logic                  temp_cool,
    input logic                  cs_fall,
    input logic [NUM_INPUTS-1:0] wet_en_o,
    input logic                  ot_alert_n,
    input logic                  ot_status
);
    // R1: reset clears every output
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (wet_en_o == '0 && ot_alert_n && !ot_status));

    // R3: direct mode removes wetting from inputs 0 and 1
    a_r3_direct_mask: assert property (@(posedge clk) disable iff (!rst_n)
        direct_mode |=> (wet_en_o[1:0] == 2'b00));

    // R4: scan mode outside the polling pulse gives no wetting
    a_r4_scan_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_mode && !poll_pulse) |=> (wet_en_o == '0));

    // R7: wetting disabled forces enables off and thermal idle
    a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !wet_enable |=> (wet_en_o == '0 && !ot_status && ot_alert_n));

    // R8: status holds until the recovery comparator reports cool
    a_r8_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_status && !temp_cool && wet_enable) |=> ot_status);

    // R9: chip-select falling edge releases the alert
    a_r9_alert_ack: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> ot_alert_n);

    // R10: overtemperature status blocks all wetting
    a_r10_hot_off: assert property (@(posedge clk) disable iff (!rst_n)
        ot_status |=> (wet_en_o == '0));
endmodule

bind wet_thermal_ctl wet_thermal_ctl_chk #(.NUM_INPUTS(NUM_INPUTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wet_enable (wet_enable),
    .direct_mode(direct_mode),
    .scan_mode  (scan_mode),
    .poll_pulse (poll_pulse),
    .temp_cool  (temp_cool),
    .cs_fall    (cs_fall),
    .wet_en_o   (wet_en_o),
    .ot_alert_n (ot_alert_n),
    .ot_status  (ot_status)
);

// File: tb/wet_thermal_ctl_tb_top.sv
// Scoreboard bench: the driver queues expected outputs with their due cycle,
// and the monitor compares them on falling clock edges.
module wet_thermal_ctl_tb_top;
    localparam int T = wt_pkg::WT_PULSE_TICKS;

    typedef struct {
        int         due;
        logic [7:0] wet;
        logic       otn;
        logic       stat;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       deb_done = 1'b0;
    logic [7:0] closed = 8'h00;
    logic       wet_enable = 1'b0;
    logic       pulse_limit = 1'b0;
    logic       direct_mode = 1'b0;
    logic       scan_mode = 1'b0;
    logic       poll_pulse = 1'b0;
    logic       temp_hot = 1'b0;
    logic       temp_cool = 1'b0;
    logic       cs_fall = 1'b0;
    logic [7:0] wet_en_o;
    logic       ot_alert_n;
    logic       ot_status;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    wet_thermal_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .deb_done(deb_done), .closed(closed),
        .wet_enable(wet_enable), .pulse_limit(pulse_limit),
        .direct_mode(direct_mode), .scan_mode(scan_mode),
        .poll_pulse(poll_pulse), .temp_hot(temp_hot), .temp_cool(temp_cool),
        .cs_fall(cs_fall), .wet_en_o(wet_en_o), .ot_alert_n(ot_alert_n),
        .ot_status(ot_status)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every expected item whose due cycle has come.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (e.due != cyc || wet_en_o !== e.wet || ot_alert_n !== e.otn
                || ot_status !== e.stat) begin
                n_fail++;
                $display("FAIL %s cyc %0d: got wet=%h otn=%b stat=%b, expected wet=%h otn=%b stat=%b (due %0d)",
                         e.tag, cyc, wet_en_o, ot_alert_n, ot_status,
                         e.wet, e.otn, e.stat, e.due);
            end
        end
    end

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_in(input int d, input logic [7:0] w, input logic otn,
                             input logic st, input string tag);
        exp_t e;
        e.due = cyc + d; e.wet = w; e.otn = otn; e.stat = st; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic finish_run();
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d items not checked, expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        tick(1);
        expect_in(1, 8'h00, 1'b1, 1'b0, "R1 reset state");
        tick(3);
        rst_n = 1'b1;

        // R2 continuous wetting follows the closed switches
        wet_enable = 1'b1;
        closed = 8'hA5;
        expect_in(1, 8'hA5, 1'b1, 1'b0, "R2 continuous A5");
        tick(2);
        closed = 8'h5A;
        expect_in(1, 8'h5A, 1'b1, 1'b0, "R2 continuous 5A");
        tick(2);

        // R3 direct-input mask on the two low inputs
        closed = 8'hFF;
        direct_mode = 1'b1;
        expect_in(1, 8'hFC, 1'b1, 1'b0, "R3 direct mask");
        tick(2);
        direct_mode = 1'b0;
        expect_in(1, 8'hFF, 1'b1, 1'b0, "R3 direct released");
        tick(2);

        // R4 scan mode: wetting only inside the polling pulse
        closed = 8'hF0;
        scan_mode = 1'b1;
        expect_in(1, 8'h00, 1'b1, 1'b0, "R4 scan no poll");
        tick(2);
        poll_pulse = 1'b1;
        expect_in(1, 8'hF0, 1'b1, 1'b0, "R4 scan in poll");
        tick(1);
        poll_pulse = 1'b0;
        expect_in(1, 8'h00, 1'b1, 1'b0, "R4 scan poll ended");
        tick(2);
        scan_mode = 1'b0;

        // R5 single timed pulse on the captured vector
        closed = 8'h3C;
        pulse_limit = 1'b1;
        deb_done = 1'b1;
        expect_in(2, 8'h3C, 1'b1, 1'b0, "R5 pulse first cycle");
        expect_in(T + 1, 8'h3C, 1'b1, 1'b0, "R5 pulse last cycle");
        expect_in(T + 2, 8'h00, 1'b1, 1'b0, "R5 pulse ended");
        tick(1);
        deb_done = 1'b0;
        closed = 8'hFF;
        tick(T + 4);

        // R6 retrigger stretches the shared pulse and recaptures
        closed = 8'h0F;
        deb_done = 1'b1;
        expect_in(2, 8'h0F, 1'b1, 1'b0, "R6 first pulse");
        tick(1);
        deb_done = 1'b0;
        tick(19);
        closed = 8'hC3;
        deb_done = 1'b1;
        expect_in(2, 8'hC3, 1'b1, 1'b0, "R6 recaptured");
        expect_in(T - 18, 8'hC3, 1'b1, 1'b0, "R6 stretched past first period");
        expect_in(T + 1, 8'hC3, 1'b1, 1'b0, "R6 restarted last cycle");
        expect_in(T + 2, 8'h00, 1'b1, 1'b0, "R6 restarted ended");
        tick(1);
        deb_done = 1'b0;
        tick(T + 4);

        // R8 R9 R10 thermal sequence in continuous mode
        pulse_limit = 1'b0;
        closed = 8'h0F;
        expect_in(1, 8'h0F, 1'b1, 1'b0, "R2 before heat");
        tick(2);
        temp_hot = 1'b1;
        expect_in(1, 8'h0F, 1'b0, 1'b1, "R8 R9 status and alert set");
        expect_in(2, 8'h00, 1'b0, 1'b1, "R10 wetting forced off");
        tick(3);
        cs_fall = 1'b1;
        expect_in(1, 8'h00, 1'b1, 1'b1, "R9 alert cleared while hot");
        tick(1);
        cs_fall = 1'b0;
        tick(3);
        expect_in(1, 8'h00, 1'b1, 1'b1, "R9 no re-assert while hot");
        tick(2);
        temp_hot = 1'b0;
        expect_in(1, 8'h00, 1'b1, 1'b1, "R8 status holds in hysteresis");
        tick(3);
        temp_cool = 1'b1;
        expect_in(1, 8'h00, 1'b1, 1'b0, "R8 status clears at recovery");
        expect_in(2, 8'h0F, 1'b1, 1'b0, "R10 wetting restored");
        tick(3);
        temp_cool = 1'b0;

        // R7 wetting disabled: enables off and thermal inactive
        wet_enable = 1'b0;
        temp_hot = 1'b1;
        expect_in(1, 8'h00, 1'b1, 1'b0, "R7 disabled ignores heat");
        tick(3);
        expect_in(1, 8'h00, 1'b1, 1'b0, "R7 still idle");
        tick(2);
        temp_hot = 1'b0;
        tick(2);

        done = 1'b1;
        finish_run();
    end
endmodule